// File: doc/BRIEF.md
# Single-to-Half Rounding Narrower

This block turns a 32-bit single-precision word into the nearest 16-bit half-precision code. Rounding is to nearest, with ties going to the even code. Each conversion takes one registered stage. A valid strobe travels with the data, and the result word is updated only when a new input is accepted. The result comes with four flags that belong to that result only: overflow, underflow, inexact and invalid.

A mode input chooses how the top exponent code is read. In standard mode, exponent code 31 holds infinities and NaNs. Any magnitude of 65520 or more becomes infinity, and NaNs come out quiet with their upper payload kept. In alternative mode, exponent code 31 is an ordinary binade, so the largest value is 131008. Magnitudes beyond that saturate, and NaN inputs collapse to +0. Half subnormals are produced with full sticky rounding, so the smallest output is 2^-24.

Top module: `fp_narrow`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by one clock. The result and flags load only on cycles where `valid_i` is high and hold otherwise. After reset, `valid_o`, the result and all flags are 0.
- R2: Normal results use round-to-nearest-even on the 10-bit stored fraction. Examples: 1.0 gives 0x3C00, 1/3 (0x3EAAAAAB) gives 0x3555, 0x3F801000 gives 0x3C00 (tie, kept even), 0x3F803000 gives 0x3C02 (tie, rounded up), and -2.0 gives 0xC000.
- R3: When rounding carries out of an all-ones fraction, the exponent goes up by one. Example: 0x3FFFF000 gives 0x4000.
- R4: In standard mode, a finite magnitude below 65520 gives at most 0x7BFF. A magnitude of 65520 or more gives ±infinity (0x7C00/0xFC00) with overflow and inexact raised. An infinity input passes through with no flags.
- R5: In standard mode, a NaN input gives sign, exponent 31, quiet bit (bit 9) set, and input fraction bits 21..13 copied to bits 8..0. Invalid is raised only when the input quiet bit (bit 22) is 0.
- R6: Values below 2^-14 become half subnormals, rounded to nearest-even using every discarded bit. 2^-24 gives 0x0001. 2^-25 gives 0x0000. 1.5·2^-25 gives 0x0001. A value that rounds up past 0x03FF gives 0x0400.
- R7: Zero inputs and single-precision subnormal inputs give a zero that keeps the input sign. A nonzero single-precision subnormal raises underflow and inexact.
- R8: In alternative mode, exponent 31 is a normal binade (0x7C00 = 65536, 0x7FFF = 131008). Larger results saturate to ±0x7FFF with overflow and inexact. Infinities saturate to ±0x7FFF with only invalid. A NaN gives 0x0000 with only invalid.
- R9: Inexact is set when any discarded input bit is nonzero. Underflow is set when the rounded result has exponent code 0 and inexact is set. Overflow always comes with inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid this cycle |
| data_i | input | 32 | Single-precision input |
| alt_mode_i | input | 1 | 1 = alternative half mode (no infinity or NaN codes) |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| half_o | output | 16 | Half-precision result |
| ovf_o | output | 1 | Overflow flag for this result |
| unf_o | output | 1 | Underflow flag for this result |
| inx_o | output | 1 | Inexact flag for this result |
| inv_o | output | 1 | Invalid flag for this result |

## Verification
The bench builds the block with its default widths only: an 8/23 input format narrowed to a 5/10 output format. With these widths the exact codes named in the requirements can be checked directly, including:
- the 65519/65520 overflow cutoff,
- ties at the lowest fraction bit,
- the carry from the largest subnormal into 0x0400,
- the alternative-mode ceiling at 131008.

Expected codes and flags are hand-derived from the requirements and compared in arrival order. This covers back-to-back inputs as well as idle gaps, where the held result is checked.

// File: rtl/fp_narrow_pkg.sv
package fp_narrow_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_TINY,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } cls_e;

  typedef struct packed {
    logic inv;
    logic ovf;
    logic unf;
    logic inx;
  } flags_t;
endpackage

// File: rtl/fp_narrow_unpack.sv
module fp_narrow_unpack #(
  parameter int IN_EXP_W = 8,
  parameter int IN_MAN_W = 23
) (
  input  logic [IN_EXP_W+IN_MAN_W:0] word_i,
  output logic                       sign_o,
  output logic [IN_EXP_W-1:0]        exp_o,
  output logic [IN_MAN_W-1:0]        man_o,
  output fp_narrow_pkg::cls_e        cls_o
);
  import fp_narrow_pkg::*;

  assign sign_o = word_i[IN_EXP_W+IN_MAN_W];
  assign exp_o  = word_i[IN_MAN_W +: IN_EXP_W];
  assign man_o  = word_i[IN_MAN_W-1:0];

  always_comb begin
    if (exp_o == '0)      cls_o = (man_o == '0) ? CLS_ZERO : CLS_TINY;
    else if (exp_o == '1) cls_o = (man_o == '0) ? CLS_INF : CLS_NAN;
    else                  cls_o = CLS_NORM;
  end
endmodule

// File: rtl/fp_narrow_round.sv
module fp_narrow_round #(
  parameter int IN_EXP_W  = 8,
  parameter int IN_MAN_W  = 23,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 10
) (
  input  logic                          sign_i,
  input  logic [IN_EXP_W-1:0]           exp_i,
  input  logic [IN_MAN_W-1:0]           man_i,
  input  fp_narrow_pkg::cls_e           cls_i,
  input  logic                          alt_i,
  output logic [OUT_EXP_W+OUT_MAN_W:0]  res_o,
  output fp_narrow_pkg::flags_t         flg_o
);
  import fp_narrow_pkg::*;

  localparam int SIG_W    = IN_MAN_W + 1;
  localparam int DROP     = IN_MAN_W - OUT_MAN_W;
  localparam int IN_BIAS  = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int SH_MAX   = SIG_W + 2;
  localparam int WIDE_W   = SIG_W + SH_MAX + 1;
  localparam int MAG_W    = OUT_EXP_W + OUT_MAN_W + 1;
  localparam int EMAX_STD = (1 << OUT_EXP_W) - 2;
  localparam int EMAX_ALT = (1 << OUT_EXP_W) - 1;
  localparam logic [MAG_W-2:0] INF_MAG = {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};
  localparam logic [MAG_W-2:0] SAT_MAG = '1;

  logic [SIG_W-1:0]     sig;
  int                   te;
  int                   sh;
  logic [WIDE_W-1:0]    wide;
  logic [OUT_MAN_W:0]   sub_f;
  logic                 sub_g, sub_s;
  logic [OUT_MAN_W-1:0] nrm_f;
  logic                 nrm_g, nrm_s;
  logic                 grd, stk, up, ovf_hit;
  logic [MAG_W-1:0]     mag;

  assign sig = {1'b1, man_i};
  assign te  = int'(exp_i) - IN_BIAS + OUT_BIAS;

  // subnormal alignment: clamp keeps every input bit inside the window for sticky
  always_comb begin
    sh = DROP + 1 - te;
    if (sh > SH_MAX) sh = SH_MAX;
    if (sh < 0)      sh = 0;
  end
  assign wide  = {sig, {(SH_MAX + 1){1'b0}}} >> sh;
  assign sub_f = wide[SH_MAX+1 +: OUT_MAN_W+1];
  assign sub_g = wide[SH_MAX];
  assign sub_s = |wide[SH_MAX-1:0];

  assign nrm_f = sig[SIG_W-2 -: OUT_MAN_W];
  assign nrm_g = sig[DROP-1];
  assign nrm_s = |sig[DROP-2:0];

  logic unused_bits;
  assign unused_bits = ^{wide[WIDE_W-1:SH_MAX+OUT_MAN_W+2], te[31:OUT_EXP_W], sig[SIG_W-1]};

  always_comb begin
    res_o   = '0;
    flg_o   = '0;
    grd     = 1'b0;
    stk     = 1'b0;
    up      = 1'b0;
    mag     = '0;
    ovf_hit = 1'b0;
    unique case (cls_i)
      CLS_ZERO: res_o = {sign_i, {(MAG_W-1){1'b0}}};
      CLS_TINY: begin
        res_o     = {sign_i, {(MAG_W-1){1'b0}}};
        flg_o.inx = 1'b1;
        flg_o.unf = 1'b1;
      end
      CLS_INF: begin
        if (alt_i) begin
          res_o     = {sign_i, SAT_MAG};
          flg_o.inv = 1'b1;
        end else begin
          res_o = {sign_i, INF_MAG};
        end
      end
      CLS_NAN: begin
        flg_o.inv = alt_i | ~man_i[IN_MAN_W-1];
        if (!alt_i)
          res_o = {sign_i, {OUT_EXP_W{1'b1}}, 1'b1, man_i[IN_MAN_W-2 -: OUT_MAN_W-1]};
      end
      default: begin
        if (te <= 0) begin
          grd = sub_g;
          stk = sub_s;
          up  = grd & (stk | sub_f[0]);
          mag = MAG_W'(sub_f) + MAG_W'(up);
        end else begin
          grd = nrm_g;
          stk = nrm_s;
          up  = grd & (stk | nrm_f[0]);
          mag = {1'b0, te[OUT_EXP_W-1:0], nrm_f} + MAG_W'(up);
        end
        flg_o.inx = grd | stk;
        if (alt_i) ovf_hit = (te > EMAX_ALT) || mag[MAG_W-1];
        else       ovf_hit = (te > EMAX_STD) || (mag[MAG_W-2 -: OUT_EXP_W] == '1);
        if (ovf_hit) begin
          flg_o.ovf = 1'b1;
          flg_o.inx = 1'b1;
          res_o     = {sign_i, alt_i ? SAT_MAG : INF_MAG};
        end else begin
          res_o     = {sign_i, mag[MAG_W-2:0]};
          flg_o.unf = (grd | stk) && (mag[MAG_W-2 -: OUT_EXP_W] == '0);
        end
      end
    endcase
  end
endmodule

// File: rtl/fp_narrow.sv
module fp_narrow #(
  parameter int IN_EXP_W  = 8,
  parameter int IN_MAN_W  = 23,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [IN_EXP_W+IN_MAN_W:0]   data_i,
  input  logic                         alt_mode_i,
  output logic                         valid_o,
  output logic [OUT_EXP_W+OUT_MAN_W:0] half_o,
  output logic                         ovf_o,
  output logic                         unf_o,
  output logic                         inx_o,
  output logic                         inv_o
);
  import fp_narrow_pkg::*;

  localparam int OUT_W = OUT_EXP_W + OUT_MAN_W + 1;
  localparam logic [OUT_W-2:0] INF_MAG = {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};

  logic                 u_sign;
  logic [IN_EXP_W-1:0]  u_exp;
  logic [IN_MAN_W-1:0]  u_man;
  cls_e                 u_cls;
  logic [OUT_W-1:0]     r_res;
  flags_t               r_flg;

  fp_narrow_unpack #(.IN_EXP_W(IN_EXP_W), .IN_MAN_W(IN_MAN_W)) u_unpack (
    .word_i (data_i),
    .sign_o (u_sign),
    .exp_o  (u_exp),
    .man_o  (u_man),
    .cls_o  (u_cls)
  );

  fp_narrow_round #(
    .IN_EXP_W (IN_EXP_W), .IN_MAN_W (IN_MAN_W),
    .OUT_EXP_W(OUT_EXP_W), .OUT_MAN_W(OUT_MAN_W)
  ) u_round (
    .sign_i (u_sign),
    .exp_i  (u_exp),
    .man_i  (u_man),
    .cls_i  (u_cls),
    .alt_i  (alt_mode_i),
    .res_o  (r_res),
    .flg_o  (r_flg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      half_o  <= '0;
      {inv_o, ovf_o, unf_o, inx_o} <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        half_o <= r_res;
        {inv_o, ovf_o, unf_o, inx_o} <= r_flg;
      end
    end
  end

  logic in_nan;
  assign in_nan = (data_i[IN_MAN_W +: IN_EXP_W] == '1) && (data_i[IN_MAN_W-1:0] != '0);

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(half_o)); // R1
  AST_STD_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !alt_mode_i) |=> (!ovf_o || half_o[OUT_W-2:0] == INF_MAG)); // R4
  AST_STD_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !alt_mode_i && in_nan) |=> (half_o[OUT_W-2 -: OUT_EXP_W+1] == '1)); // R5
  AST_ALT_NAN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && alt_mode_i && in_nan) |=> (half_o == '0 && inv_o && !ovf_o)); // R8
  AST_UNF_INX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> inx_o); // R9
  AST_OVF_INX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> inx_o); // R9
endmodule

// File: tb/fp_narrow_bench.sv
`timescale 1ns/1ps
module fp_narrow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        alt_i = 1'b0;
  logic        valid_o, ovf_o, unf_o, inx_o, inv_o;
  logic [15:0] half_o;

  always #2 clk = ~clk;

  fp_narrow u_fp_narrow (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .alt_mode_i(alt_i), .valid_o(valid_o), .half_o(half_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .inx_o(inx_o), .inv_o(inv_o)
  );

  typedef struct {
    logic [15:0] h;
    logic [3:0]  f;   // {inv, ovf, unf, inx}
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] last_h = '0;

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic a, input logic [15:0] eh,
                      input logic [3:0] ef, input string tag);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1;
    data_i  = d;
    alt_i   = a;
    e.h = eh; e.f = ef; e.tag = tag;
    q.push_back(e);
    last_h = eh;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      data_i  = 32'hDEAD_BEEF;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 unexpected valid_o", {4'h0, half_o}, 20'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({half_o, inv_o, ovf_o, unf_o, inx_o} == {e.h, e.f}, e.tag,
              {half_o, inv_o, ovf_o, unf_o, inx_o}, {e.h, e.f});
      end
    end
  end

  bit timeout = 1'b0;

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check({valid_o, half_o, inv_o, ovf_o, unf_o, inx_o} == '0, "R1 reset state",
              {half_o, inv_o, ovf_o, unf_o, inx_o}, 20'h0);
        rst_n = 1'b1;
        idle(2);
        // R2 rounding on normals
        send(32'h3F80_0000, 0, 16'h3C00, 4'b0000, "R2 one");
        send(32'h3EAA_AAAB, 0, 16'h3555, 4'b0001, "R2 one third");
        send(32'h3F80_1000, 0, 16'h3C00, 4'b0001, "R2 tie to even down");
        send(32'h3F80_3000, 0, 16'h3C02, 4'b0001, "R2 tie to even up");
        send(32'h3F80_1001, 0, 16'h3C01, 4'b0001, "R2 above half");
        send(32'hC000_0000, 0, 16'hC000, 4'b0000, "R2 minus two");
        send(32'h3F80_0001, 0, 16'h3C00, 4'b0001, "R9 sticky only inexact");
        // R3 carry into exponent
        send(32'h3FFF_F000, 0, 16'h4000, 4'b0001, "R3 fraction carry");
        idle(3);
        check(half_o == last_h && !valid_o, "R1 hold when idle", {4'h0, half_o}, {4'h0, last_h});
        // R4 overflow cutoff
        send(32'h477F_E000, 0, 16'h7BFF, 4'b0000, "R4 65504 exact");
        send(32'h477F_EFFF, 0, 16'h7BFF, 4'b0001, "R4 just below 65520");
        send(32'h477F_F000, 0, 16'h7C00, 4'b0101, "R4 65520 to inf");
        send(32'hC780_0000, 0, 16'hFC00, 4'b0101, "R4 -65536 to -inf");
        send(32'h7F80_0000, 0, 16'h7C00, 4'b0000, "R4 inf passes");
        send(32'hFF80_0000, 0, 16'hFC00, 4'b0000, "R4 -inf passes");
        // R5 NaN
        send(32'h7FC0_0000, 0, 16'h7E00, 4'b0000, "R5 quiet nan");
        send(32'h7F80_0001, 0, 16'h7E00, 4'b1000, "R5 signaling nan");
        send(32'hFFA0_0000, 0, 16'hFF00, 4'b1000, "R5 neg snan payload");
        send(32'h7FC0_2000, 0, 16'h7E01, 4'b0000, "R5 payload low bit");
        idle(1);
        // R6 subnormals
        send(32'h3380_0000, 0, 16'h0001, 4'b0000, "R6 min subnormal");
        send(32'h3300_0000, 0, 16'h0000, 4'b0011, "R6 half min tie to zero");
        send(32'h3340_0000, 0, 16'h0001, 4'b0011, "R6 above half min");
        send(32'h3880_0000, 0, 16'h0400, 4'b0000, "R6 min normal");
        send(32'h387F_C000, 0, 16'h03FF, 4'b0000, "R6 max subnormal");
        send(32'h387F_FFFF, 0, 16'h0400, 4'b0001, "R6 carry to normal");
        // R7 zeros
        send(32'h8000_0000, 0, 16'h8000, 4'b0000, "R7 minus zero");
        send(32'h0000_0000, 0, 16'h0000, 4'b0000, "R7 plus zero");
        send(32'h8000_0001, 0, 16'h8000, 4'b0011, "R7 tiny single");
        idle(2);
        check(half_o == last_h, "R1 hold after gap", {4'h0, half_o}, {4'h0, last_h});
        // R8 alternative mode
        send(32'h477F_F000, 1, 16'h7C00, 4'b0001, "R8 65520 stays finite");
        send(32'h4780_0000, 1, 16'h7C00, 4'b0000, "R8 65536 exact");
        send(32'h47FF_E000, 1, 16'h7FFF, 4'b0000, "R8 131008 exact");
        send(32'h47FF_F000, 1, 16'h7FFF, 4'b0101, "R8 carry past top");
        send(32'hC800_0000, 1, 16'hFFFF, 4'b0101, "R8 neg saturate");
        send(32'h7F80_0000, 1, 16'h7FFF, 4'b1000, "R8 inf saturates");
        send(32'hFF80_0000, 1, 16'hFFFF, 4'b1000, "R8 -inf saturates");
        send(32'hFFC0_0000, 1, 16'h0000, 4'b1000, "R8 nan to zero");
        send(32'h3EAA_AAAB, 1, 16'h3555, 4'b0001, "R8 one third");
        send(32'h3300_0000, 1, 16'h0000, 4'b0011, "R8 underflow");
        idle(4);
        check(q.size() == 0, "R1 all results arrived", 20'(q.size()), 20'h0);
      end
      begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) check(1'b0, "watchdog", 20'h1, 20'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule